// File: doc/BRIEF.md
# Base and Limit Address Relocator

This block sits between a processor and memory. It turns each logical address into a physical address and checks that the access is allowed. For each of several address-space contexts it keeps a relocation base and an upper bound. A request names a context and a logical address. The block compares the address against that context's bound and, in the same cycle, adds the context's base to the address. The result goes into a one-entry response register, which has a valid/ready handshake.

An address above the bound gives a fault response, and the physical address on that response is forced to zero. An address at or below the bound gives the sum of base and address, wrapped to the physical width. Only privileged software can reload the base and bound registers, for example when it moves an address space or switches context. The write port has a privilege qualifier. A write without it leaves the registers untouched, and the block reports a one-cycle denial pulse.

Top module: `base_limit_relocator`

## Requirements
- R1: After reset, rsp_valid and cfg_denied are low and req_ready is high. Every context has base 0 and bound 0, so logical address 0 translates to physical 0 and address 1 faults.
- R2: When the logical address is at or below the context's bound, the response has rsp_fault low. rsp_paddr equals (base + logical address) modulo 2^PA_W.
- R3: When the logical address is above the bound, the response has rsp_fault high and rsp_paddr equal to zero.
- R4: A logical address exactly equal to the bound is translated and does not fault.
- R5: A request is accepted when req_valid and req_ready are both high. Its response appears with rsp_valid high on the next clock edge.
- R6: While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_fault and rsp_paddr hold their values, and req_ready is low.
- R7: A write with cfg_we and cfg_priv both high loads cfg_data into the context selected by cfg_ctx. cfg_sel = 0 selects the base register. cfg_sel = 1 selects the bound register, which takes the low LA_W bits of cfg_data. The new value applies to requests accepted after the write cycle.
- R8: A write with cfg_we high and cfg_priv low changes no register. cfg_denied is high for exactly the one cycle after such a write.
- R9: A write to one context leaves the translations of all other contexts unchanged.
- R10: A request accepted in the same cycle as a write to its context is translated with the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_priv | input | 1 | Writer is in privileged mode |
| cfg_ctx | input | CTX_W | Context whose register is written |
| cfg_sel | input | 1 | 0 = base, 1 = bound |
| cfg_data | input | PA_W | Write data |
| cfg_denied | output | 1 | Pulse: previous write was rejected |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can take a request |
| req_ctx | input | CTX_W | Context of the request |
| req_addr | input | LA_W | Logical address |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 1 | Protection fault |
| rsp_paddr | output | PA_W | Physical address, zero on fault |

## Verification
The bench programs the four contexts and then sweeps every logical address through each of them. This covers the address equal to the bound, the address one above it and a base that makes the sum wrap. An off-by-one compare would either fault at the bound or let the next address through. A design that does not gate the output would leak a nonzero address on a fault. The bench also lines a register write up with a request in the same cycle, to catch a design that forwards the new value early. It tries unprivileged writes and checks that every context still translates as before. Under back-pressure it checks that a held response does not change and that no new request is taken.

// File: rtl/reloc_pkg.sv
package reloc_pkg;
  typedef enum logic {
    SEL_BASE  = 1'b0,
    SEL_BOUND = 1'b1
  } reloc_sel_e;
endpackage

// File: rtl/reloc_regfile.sv
module reloc_regfile #(
  parameter int CTX_N = 4,
  parameter int LA_W  = 8,
  parameter int PA_W  = 10,
  parameter int CTX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_priv,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_data,
  input  logic [CTX_W-1:0] rd_ctx,
  output logic [PA_W-1:0]  rd_base,
  output logic [LA_W-1:0]  rd_bound,
  output logic             cfg_denied
);
  import reloc_pkg::*;

  logic [CTX_N-1:0][PA_W-1:0] base_q;
  logic [CTX_N-1:0][LA_W-1:0] bound_q;
  logic                       denied_q;

  // Named write events, used by the assertions below
  logic priv_write;
  logic user_write;
  assign priv_write = cfg_we & cfg_priv;
  assign user_write = cfg_we & ~cfg_priv;

  for (genvar c = 0; c < CTX_N; c++) begin : g_ctx
    logic hit;
    assign hit = priv_write && (cfg_ctx == CTX_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[c]  <= '0;
        bound_q[c] <= '0;
      end else if (hit) begin
        if (reloc_sel_e'(cfg_sel) == SEL_BASE) base_q[c] <= cfg_data;
        else                                   bound_q[c] <= cfg_data[LA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) denied_q <= 1'b0;
    else        denied_q <= user_write;
  end

  assign rd_base    = base_q[rd_ctx];
  assign rd_bound   = bound_q[rd_ctx];
  assign cfg_denied = denied_q;

  AST_USER_WRITE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    user_write |=> ($stable(base_q) && $stable(bound_q))); // R8
  AST_DENY_FOLLOWS_USER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    user_write |=> cfg_denied); // R8
  AST_DENY_ONLY_AFTER_USER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !user_write |=> !cfg_denied); // R8
  AST_IDLE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_write |=> ($stable(base_q) && $stable(bound_q))); // R9
endmodule

// File: rtl/reloc_xlate.sv
module reloc_xlate #(
  parameter int LA_W = 8,
  parameter int PA_W = 10
) (
  input  logic [LA_W-1:0] laddr,
  input  logic [PA_W-1:0] base,
  input  logic [LA_W-1:0] bound,
  output logic            in_range,
  output logic [PA_W-1:0] paddr_sum,
  output logic [PA_W-1:0] paddr_out
);
  localparam int SUM_W = (PA_W > LA_W) ? PA_W : LA_W;

  // Relocation: base plus address, wrapped to the physical width
  function automatic logic [PA_W-1:0] relocate(input logic [PA_W-1:0] b,
                                               input logic [LA_W-1:0] a);
    logic [SUM_W-1:0] s;
    s = SUM_W'(b) + SUM_W'(a);
    return s[PA_W-1:0];
  endfunction

  // Protection: inclusive upper bound
  function automatic logic within_bound(input logic [LA_W-1:0] a,
                                       input logic [LA_W-1:0] lim);
    return a <= lim;
  endfunction

  // Both paths evaluate side by side; the gate only joins them at the end
  assign paddr_sum = relocate(base, laddr);
  assign in_range  = within_bound(laddr, bound);
  assign paddr_out = in_range ? paddr_sum : '0;
endmodule

// File: rtl/reloc_rsp_stage.sv
module reloc_rsp_stage #(
  parameter int PA_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            in_fault,
  input  logic [PA_W-1:0] in_paddr,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_fault,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            req_fire
);
  logic            valid_q;
  logic            fault_q;
  logic [PA_W-1:0] paddr_q;

  assign req_ready = !valid_q || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else if (req_fire) begin
      valid_q <= 1'b1;
      fault_q <= in_fault;
      paddr_q <= in_paddr;
    end else if (rsp_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;

  AST_ACCEPT_GIVES_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid); // R5
  AST_RESPONSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_fault) && $stable(rsp_paddr))); // R6
  AST_NO_ACCEPT_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R6
endmodule

// File: rtl/base_limit_relocator.sv
module base_limit_relocator #(
  parameter int CTX_N = 4,
  parameter int LA_W  = 8,
  parameter int PA_W  = 10,
  localparam int CTX_W = (CTX_N > 1) ? $clog2(CTX_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_priv,
  input  logic [CTX_W-1:0] cfg_ctx,
  input  logic             cfg_sel,
  input  logic [PA_W-1:0]  cfg_data,
  output logic             cfg_denied,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CTX_W-1:0] req_ctx,
  input  logic [LA_W-1:0]  req_addr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  logic [PA_W-1:0] sel_base;
  logic [LA_W-1:0] sel_bound;
  logic            in_range;
  logic [PA_W-1:0] paddr_sum;
  logic [PA_W-1:0] paddr_gated;
  logic            req_fire;

  reloc_regfile #(.CTX_N(CTX_N), .LA_W(LA_W), .PA_W(PA_W), .CTX_W(CTX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_ctx(cfg_ctx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rd_ctx(req_ctx), .rd_base(sel_base), .rd_bound(sel_bound),
    .cfg_denied(cfg_denied)
  );

  reloc_xlate #(.LA_W(LA_W), .PA_W(PA_W)) u_xlate (
    .laddr(req_addr), .base(sel_base), .bound(sel_bound),
    .in_range(in_range), .paddr_sum(paddr_sum), .paddr_out(paddr_gated)
  );

  reloc_rsp_stage #(.PA_W(PA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .in_fault(!in_range), .in_paddr(paddr_gated),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .req_fire(req_fire)
  );

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R3
  AST_FAULT_FROM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (rsp_fault == ($past(req_addr) > $past(sel_bound)))); // R2
  AST_GOOD_ADDR_IS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && in_range) |=> (rsp_paddr == $past(paddr_sum))); // R2
endmodule

// File: tb/tb_base_limit_relocator.sv
`timescale 1ns/1ps
module tb_base_limit_relocator;
  localparam int CTX_N = 4;
  localparam int LA_W  = 8;
  localparam int PA_W  = 10;
  localparam int CTX_W = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0, cfg_priv = 1'b0, cfg_sel = 1'b0;
  logic [CTX_W-1:0] cfg_ctx = '0;
  logic [PA_W-1:0]  cfg_data = '0;
  logic             cfg_denied;
  logic             req_valid = 1'b0, rsp_ready = 1'b1;
  logic             req_ready;
  logic [CTX_W-1:0] req_ctx = '0;
  logic [LA_W-1:0]  req_addr = '0;
  logic             rsp_valid, rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;

  int base_m [CTX_N];
  int bound_m[CTX_N];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  base_limit_relocator #(.CTX_N(CTX_N), .LA_W(LA_W), .PA_W(PA_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_ctx(cfg_ctx),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_denied(cfg_denied),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_ctx(req_ctx), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected translation from the requirements
  function automatic int exp_pa(input int b, input int a);
    return (b + a) % (1 << PA_W);
  endfunction

  task automatic wr(input bit priv, input int ctx, input bit sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = priv; cfg_ctx = CTX_W'(ctx);
    cfg_sel = sel; cfg_data = PA_W'(data);
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0;
    if (priv) begin
      if (sel) bound_m[ctx] = data % (1 << LA_W);
      else     base_m[ctx]  = data;
    end
  endtask

  // One access with immediate response consumption; checks fault and address
  task automatic access(input int ctx, input int addr, input string req);
    bit ef;
    int ea;
    ef = addr > bound_m[ctx];
    ea = ef ? 0 : exp_pa(base_m[ctx], addr);
    @(negedge clk);
    req_valid = 1'b1; req_ctx = CTX_W'(ctx); req_addr = LA_W'(addr); rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid == 1'b1, {req, " R5 valid"}, int'(rsp_valid), 1);
    check(rsp_fault == ef, {req, " fault"}, int'(rsp_fault), int'(ef));
    check(int'(rsp_paddr) == ea, {req, " paddr"}, int'(rsp_paddr), ea);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < CTX_N; c++) begin base_m[c] = 0; bound_m[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(cfg_denied == 1'b0, "R1 cfg_denied", int'(cfg_denied), 0);
    check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    for (int c = 0; c < CTX_N; c++) begin
      access(c, 0, "R1 addr0");
      access(c, 1, "R1 addr1");
    end

    // R7 program every context; context 3 wraps past the physical top
    wr(1, 0, 0, 100);  wr(1, 0, 1, 63);
    wr(1, 1, 0, 512);  wr(1, 1, 1, 255);
    wr(1, 2, 0, 0);    wr(1, 2, 1, 0);
    wr(1, 3, 0, 1000); wr(1, 3, 1, 200);

    // R2 R3 R4 full sweep of every address through every context
    for (int c = 0; c < CTX_N; c++)
      for (int a = 0; a < (1 << LA_W); a++)
        access(c, a, (a == bound_m[c]) ? "R4 at bound" : "R2/R3 sweep");

    // R8 unprivileged writes are ignored and flagged
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = 1'b0; cfg_ctx = 2'd1; cfg_sel = 1'b0; cfg_data = 10'd7;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_denied == 1'b1, "R8 denied pulse", int'(cfg_denied), 1);
    @(negedge clk);
    check(cfg_denied == 1'b0, "R8 pulse one cycle", int'(cfg_denied), 0);
    wr(0, 0, 1, 5);
    access(1, 10, "R8 base kept");
    access(0, 63, "R8 bound kept");
    access(0, 64, "R8 bound kept above");
    check(cfg_denied == 1'b0, "R8 no pulse on priv", int'(cfg_denied), 0);

    // R9 reload one context, others unchanged
    wr(1, 2, 0, 300); wr(1, 2, 1, 20);
    access(2, 20, "R9 reloaded at bound");
    access(2, 21, "R9 reloaded above");
    access(0, 50, "R9 ctx0 intact");
    access(1, 255, "R9 ctx1 intact");
    access(3, 100, "R9 ctx3 intact");

    // R10 same-cycle write and request use the old base
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = 1'b1; cfg_ctx = 2'd1; cfg_sel = 1'b0; cfg_data = 10'd40;
    req_valid = 1'b1; req_ctx = 2'd1; req_addr = 8'd5; rsp_ready = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_priv = 1'b0; req_valid = 1'b0;
    check(int'(rsp_paddr) == exp_pa(512, 5), "R10 old base", int'(rsp_paddr), exp_pa(512, 5));
    base_m[1] = 40;
    access(1, 5, "R10 new base after");

    // R6 back-pressure holds the response
    @(negedge clk);
    req_valid = 1'b1; req_ctx = 2'd0; req_addr = 8'd9; rsp_ready = 1'b0;
    @(negedge clk);
    req_addr = 8'd200; req_ctx = 2'd0;
    check(req_ready == 1'b0, "R6 ready low", int'(req_ready), 0);
    repeat (2) @(negedge clk);
    check(rsp_valid == 1'b1, "R6 valid held", int'(rsp_valid), 1);
    check(int'(rsp_paddr) == exp_pa(100, 9), "R6 paddr held", int'(rsp_paddr), exp_pa(100, 9));
    check(rsp_fault == 1'b0, "R6 fault held", int'(rsp_fault), 0);
    req_valid = 1'b0; rsp_ready = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R5 drain", int'(rsp_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule